// File: doc/BRIEF.md
# Readout Frame Header Capture

A front-end readout chip sends each event as a serial frame. The frame opens with a run of status header slots and then carries the multiplexed analogue channel slots. Each slot is one period of the slot clock, which is 25 ns. The header slots carry live chip status, such as the parity of the configuration registers and the pipeline column that was read out. This block therefore does not throw them away. It strobes the ADC on every slot of the frame, headers included, in a single pass. It then steers each converted word to one of two FIFOs. Header words go to a header FIFO and channel words go to a channel FIFO, and both keep their bits and their order. A processor later drains both FIFOs for each event.

A frame-start pulse arms the slot sequencer. Slots 0 to 15 are header slots and slots 16 to 143 are channel slots. After the final slot the block returns to idle. If the target FIFO reports full when a word is due, the block does three things:
- it drops the rest of that frame;
- it raises a sticky overflow flag;
- it gives no completion pulse.

A start pulse that arrives while a frame is still running has no effect on the sequence. Each such pulse is counted in a saturating error counter.

Top module: `frame_slot_router`

## Requirements
- R1: After a synchronous reset, the following outputs are 0: every write strobe, the sample strobe, busy, done, overflow and the error count. This holds whether the reset came from idle or from the middle of a frame.
- R2: A frame-start pulse seen at a clock edge while idle makes adc_sample_o high for the next 144 consecutive cycles, one cycle per slot. busy_o is high over the same cycles.
- R3: The words presented on adc_data_i during strobe cycles 0 to 15 are written to the header FIFO, one per slot, in slot order and unchanged. Each write (hdr_wr_o high, hdr_data_o holding the word) happens in the cycle after its strobe cycle.
- R4: The words presented during strobe cycles 16 to 143 are written to the channel FIFO in the same way, using chn_wr_o and chn_data_o. A full flag on the FIFO that is not the target of the current slot has no effect.
- R5: The header and channel write strobes are never high in the same cycle. The data outputs change only when their own write strobe is high.
- R6: If the target FIFO's full flag is high in a strobe cycle, four things follow. That slot is not written. overflow_o rises and stays high until reset. The strobe stops and no further words of that frame are written. No done pulse follows.
- R7: frame_done_o is high for one cycle, the cycle of the final channel write. It appears only for a frame whose 16 header words and 128 channel words were all written.
- R8: A frame-start pulse seen at an edge while busy, including the edge that ends the last slot, does not restart or extend the frame. It increments err_cnt_o by one, and the count saturates at its all-ones value.
- R9: Once a frame ends or is aborted, busy_o is low in the next cycle, and a later frame-start pulse is accepted as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one period per slot |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Frame-start pulse from the readout chip |
| adc_data_i | input | SAMPLE_W | Converted word for the current strobe cycle |
| hdr_full_i | input | 1 | Header FIFO full flag |
| chn_full_i | input | 1 | Channel FIFO full flag |
| adc_sample_o | output | 1 | ADC sample strobe, high in each slot of a live frame |
| hdr_wr_o | output | 1 | Header FIFO write strobe |
| hdr_data_o | output | SAMPLE_W | Header FIFO write data |
| chn_wr_o | output | 1 | Channel FIFO write strobe |
| chn_data_o | output | SAMPLE_W | Channel FIFO write data |
| busy_o | output | 1 | A frame is being sequenced |
| frame_done_o | output | 1 | One-cycle pulse for a completely captured frame |
| overflow_o | output | 1 | Sticky flag: a frame was cut short by a full FIFO |
| err_cnt_o | output | ERR_W | Saturating count of start pulses that arrived while busy |

## Verification
Two functions meet in the cycle of slot 143. The completion logic wants to finish the frame and raise done, while a new frame-start pulse wants either to be rejected or to start a new frame. The bench drives a start pulse in exactly that strobe cycle. It expects the done pulse, an idle cycle afterwards, and the error count to advance by one. The bench also puts a channel-full flag and a start pulse in the same final slot. In that case the overflow abort, the rejected restart and the missing done pulse all have to be resolved at one edge. A behavioural model predicts every output on every cycle for both cases.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        SK_NONE = 2'd0,
        SK_HDR  = 2'd1,
        SK_CHN  = 2'd2
    } slot_kind_e;

    typedef struct packed {
        logic       live;
        slot_kind_e kind;
        logic       last;
    } slot_tag_t;

    function automatic slot_tag_t make_tag(logic live, logic is_hdr, logic last);
        slot_tag_t t;
        t.live = live;
        t.kind = !live ? SK_NONE : (is_hdr ? SK_HDR : SK_CHN);
        t.last = live & last;
        return t;
    endfunction

    function automatic logic [1:0] lane_select(slot_tag_t t);
        return {t.kind == SK_CHN, t.kind == SK_HDR};
    endfunction

endpackage

// File: rtl/fsr_sequencer.sv
module fsr_sequencer
    import fsr_pkg::*;
#(
    parameter int HDR_SLOTS = 16,
    parameter int CHN_SLOTS = 128
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      abort_i,
    output slot_tag_t tag_o,
    output logic      start_rej_o
);
    localparam int TOTAL = HDR_SLOTS + CHN_SLOTS;
    localparam int IDX_W = $clog2(TOTAL);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
    localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(HDR_SLOTS);

    logic             live_q;
    logic [IDX_W-1:0] idx_q;
    logic             at_last;

    assign at_last     = (idx_q == LAST_IDX);
    assign start_rej_o = start_i & live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            idx_q  <= '0;
        end else if (!live_q) begin
            if (start_i) begin
                live_q <= 1'b1;
                idx_q  <= '0;
            end
        end else if (abort_i || at_last) begin
            live_q <= 1'b0;
        end else begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign tag_o = make_tag(live_q, idx_q < HDR_END, at_last);

endmodule

// File: rtl/fsr_router.sv
module fsr_router #(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          lane_sel_i,
    input  logic [1:0]          full_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                blocked_o,
    output logic [1:0]          wr_o,
    output logic [SAMPLE_W-1:0] data_o [2]
);
    logic [1:0] go;

    assign go        = lane_sel_i & ~full_i;
    assign blocked_o = |(lane_sel_i & full_i);

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic                wr_q;
        logic [SAMPLE_W-1:0] data_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                wr_q   <= 1'b0;
                data_q <= '0;
            end else begin
                wr_q <= go[g];
                if (go[g]) begin
                    data_q <= sample_i;
                end
            end
        end

        assign wr_o[g]   = wr_q;
        assign data_o[g] = data_q;
    end

endmodule

// File: rtl/fsr_status.sv
module fsr_status #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             finish_i,
    input  logic             blocked_i,
    input  logic             reject_i,
    output logic             done_o,
    output logic             overflow_o,
    output logic [ERR_W-1:0] err_cnt_o
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o     <= 1'b0;
            overflow_o <= 1'b0;
            err_cnt_o  <= '0;
        end else begin
            done_o <= finish_i;
            if (blocked_i) begin
                overflow_o <= 1'b1;
            end
            if (reject_i && err_cnt_o != ERR_MAX) begin
                err_cnt_o <= err_cnt_o + 1'b1;
            end
        end
    end

endmodule

// File: rtl/frame_slot_router.sv
module frame_slot_router
    import fsr_pkg::*;
#(
    parameter int HDR_SLOTS = 16,
    parameter int CHN_SLOTS = 128,
    parameter int SAMPLE_W  = 12,
    parameter int ERR_W     = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start_i,
    input  logic [SAMPLE_W-1:0] adc_data_i,
    input  logic                hdr_full_i,
    input  logic                chn_full_i,
    output logic                adc_sample_o,
    output logic                hdr_wr_o,
    output logic [SAMPLE_W-1:0] hdr_data_o,
    output logic                chn_wr_o,
    output logic [SAMPLE_W-1:0] chn_data_o,
    output logic                busy_o,
    output logic                frame_done_o,
    output logic                overflow_o,
    output logic [ERR_W-1:0]    err_cnt_o
);
    slot_tag_t           tag;
    logic                start_rej;
    logic                blocked;
    logic [1:0]          wr_v;
    logic [SAMPLE_W-1:0] data_v [2];

    fsr_sequencer #(
        .HDR_SLOTS (HDR_SLOTS),
        .CHN_SLOTS (CHN_SLOTS)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (frame_start_i),
        .abort_i     (blocked),
        .tag_o       (tag),
        .start_rej_o (start_rej)
    );

    fsr_router #(
        .SAMPLE_W (SAMPLE_W)
    ) rte_i (
        .clk        (clk),
        .rst        (rst),
        .lane_sel_i (lane_select(tag)),
        .full_i     ({chn_full_i, hdr_full_i}),
        .sample_i   (adc_data_i),
        .blocked_o  (blocked),
        .wr_o       (wr_v),
        .data_o     (data_v)
    );

    fsr_status #(
        .ERR_W (ERR_W)
    ) sts_i (
        .clk        (clk),
        .rst        (rst),
        .finish_i   (tag.last & ~blocked),
        .blocked_i  (blocked),
        .reject_i   (start_rej),
        .done_o     (frame_done_o),
        .overflow_o (overflow_o),
        .err_cnt_o  (err_cnt_o)
    );

    assign adc_sample_o = tag.live;
    assign busy_o       = tag.live;
    assign hdr_wr_o     = wr_v[0];
    assign hdr_data_o   = data_v[0];
    assign chn_wr_o     = wr_v[1];
    assign chn_data_o   = data_v[1];

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
    parameter int HDR_SLOTS = 16,
    parameter int CHN_SLOTS = 128,
    parameter int ERR_W     = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_start_i,
    input logic             adc_sample_o,
    input logic             hdr_wr_o,
    input logic             chn_wr_o,
    input logic             busy_o,
    input logic             frame_done_o,
    input logic             overflow_o,
    input logic [ERR_W-1:0] err_cnt_o
);
    logic [15:0] hdr_cnt;
    logic [15:0] chn_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_cnt <= '0;
            chn_cnt <= '0;
        end else if (frame_start_i && !busy_o) begin
            hdr_cnt <= '0;
            chn_cnt <= '0;
        end else begin
            hdr_cnt <= hdr_cnt + 16'(hdr_wr_o);
            chn_cnt <= chn_cnt + 16'(chn_wr_o);
        end
    end

    a_r2_start_strobes: assert property (@(posedge clk) disable iff (rst)
        (frame_start_i && !busy_o) |=> adc_sample_o);

    a_r3_hdr_after_strobe: assert property (@(posedge clk) disable iff (rst)
        hdr_wr_o |-> $past(adc_sample_o));

    a_r4_chn_after_header: assert property (@(posedge clk) disable iff (rst)
        chn_wr_o |-> (hdr_cnt == 16'(HDR_SLOTS)));

    a_r5_one_lane: assert property (@(posedge clk) disable iff (rst)
        !(hdr_wr_o && chn_wr_o));

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);

    a_r6_ovf_stops: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow_o) |-> !adc_sample_o);

    a_r7_done_full_frame: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> (chn_wr_o && hdr_cnt == 16'(HDR_SLOTS)
                          && chn_cnt == 16'(CHN_SLOTS - 1)));

    a_r8_err_step: assert property (@(posedge clk) disable iff (rst)
        (frame_start_i && busy_o && err_cnt_o != '1)
            |=> err_cnt_o == $past(err_cnt_o) + 1'b1);

endmodule

bind frame_slot_router fsr_checker #(
    .HDR_SLOTS (HDR_SLOTS),
    .CHN_SLOTS (CHN_SLOTS),
    .ERR_W     (ERR_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .frame_start_i (frame_start_i),
    .adc_sample_o  (adc_sample_o),
    .hdr_wr_o      (hdr_wr_o),
    .chn_wr_o      (chn_wr_o),
    .busy_o        (busy_o),
    .frame_done_o  (frame_done_o),
    .overflow_o    (overflow_o),
    .err_cnt_o     (err_cnt_o)
);

// File: tb/frame_slot_router_tb_top.sv
`timescale 1ns/1ps
module frame_slot_router_tb_top;
    localparam int HDR = 16;
    localparam int CHN = 128;
    localparam int TOT = HDR + CHN;
    localparam int DW  = 12;
    localparam int EW  = 8;
    localparam int EMAX = (1 << EW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_start_i = 1'b0;
    logic [DW-1:0] adc_data_i = '0;
    logic          hdr_full_i = 1'b0;
    logic          chn_full_i = 1'b0;
    logic          adc_sample_o, hdr_wr_o, chn_wr_o, busy_o, frame_done_o, overflow_o;
    logic [DW-1:0] hdr_data_o, chn_data_o;
    logic [EW-1:0] err_cnt_o;

    frame_slot_router #(
        .HDR_SLOTS (HDR), .CHN_SLOTS (CHN), .SAMPLE_W (DW), .ERR_W (EW)
    ) dut_i (
        .clk (clk), .rst (rst), .frame_start_i (frame_start_i),
        .adc_data_i (adc_data_i), .hdr_full_i (hdr_full_i), .chn_full_i (chn_full_i),
        .adc_sample_o (adc_sample_o), .hdr_wr_o (hdr_wr_o), .hdr_data_o (hdr_data_o),
        .chn_wr_o (chn_wr_o), .chn_data_o (chn_data_o), .busy_o (busy_o),
        .frame_done_o (frame_done_o), .overflow_o (overflow_o), .err_cnt_o (err_cnt_o)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit cmp_en = 1'b0;
    int gen_mode = 0;
    int gen_cnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference state
    int m_busy = 0, m_slot = 0, m_ovf = 0, m_err = 0, m_done = 0;
    int m_hwr = 0, m_cwr = 0, m_hdata = 0, m_cdata = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_slot = 0; m_ovf = 0; m_err = 0; m_done = 0;
            m_hwr = 0; m_cwr = 0; m_hdata = 0; m_cdata = 0;
        end else begin
            m_hwr = 0; m_cwr = 0; m_done = 0;
            if (m_busy != 0) begin
                if (frame_start_i && m_err < EMAX) m_err++;
                if ((m_slot < HDR) ? hdr_full_i : chn_full_i) begin
                    m_ovf = 1;
                    m_busy = 0;
                end else begin
                    if (m_slot < HDR) begin m_hwr = 1; m_hdata = int'(adc_data_i); end
                    else begin m_cwr = 1; m_cdata = int'(adc_data_i); end
                    if (m_slot == TOT - 1) begin m_busy = 0; m_done = 1; end
                    else m_slot++;
                end
            end else if (frame_start_i) begin
                m_busy = 1;
                m_slot = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(adc_sample_o == m_busy[0], "R2", "sample strobe", adc_sample_o, m_busy);
            chk(busy_o == m_busy[0], "R9", "busy", busy_o, m_busy);
            chk(hdr_wr_o == m_hwr[0], "R3", "header write", hdr_wr_o, m_hwr);
            chk(int'(hdr_data_o) == m_hdata, "R3", "header data", hdr_data_o, m_hdata);
            chk(chn_wr_o == m_cwr[0], "R4", "channel write", chn_wr_o, m_cwr);
            chk(int'(chn_data_o) == m_cdata, "R4", "channel data", chn_data_o, m_cdata);
            chk(!(hdr_wr_o && chn_wr_o), "R5", "both writes", 1, 0);
            chk(overflow_o == m_ovf[0], "R6", "overflow", overflow_o, m_ovf);
            chk(frame_done_o == m_done[0], "R7", "frame done", frame_done_o, m_done);
            chk(int'(err_cnt_o) == m_err, "R8", "error count", err_cnt_o, m_err);
        end
    end

    function automatic logic [DW-1:0] next_sample();
        gen_cnt++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (gen_mode)
            0: return DW'(gen_cnt);
            1: return lfsr[DW-1:0];
            default: return gen_cnt[0] ? 12'hAAA : 12'h555;
        endcase
    endfunction

    task automatic cyc(bit fs, bit hf, bit cf);
        @(negedge clk);
        frame_start_i = fs;
        hdr_full_i = hf;
        chn_full_i = cf;
        adc_data_i = next_sample();
    endtask

    // call i of the slot loop lands in strobe cycle of slot i
    task automatic frame(int hf_slot, int cf_slot, int rs_slot, bit hold_fs, bit cf_in_hdr);
        cyc(1'b1, 1'b0, 1'b0);
        for (int s = 0; s < TOT; s++)
            cyc(hold_fs || s == rs_slot, s == hf_slot, s == cf_slot || (cf_in_hdr && s < HDR));
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
    endtask

    task automatic reset_check(string tag);
        @(negedge clk);
        chk(adc_sample_o == 0 && busy_o == 0 && hdr_wr_o == 0 && chn_wr_o == 0,
            "R1", {tag, " strobes"}, {adc_sample_o, busy_o, hdr_wr_o, chn_wr_o}, 0);
        chk(frame_done_o == 0 && overflow_o == 0 && err_cnt_o == 0,
            "R1", {tag, " status"}, {frame_done_o, overflow_o, err_cnt_o}, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        reset_check("after reset");
        rst = 1'b0;
        cmp_en = 1'b1;
        repeat (2) cyc(1'b0, 1'b0, 1'b0);

        gen_mode = 0; frame(-1, -1, -1, 1'b0, 1'b0);   // R2 R3 R4 R7 plain frame
        gen_mode = 1; frame(-1, -1, 40, 1'b0, 1'b1);   // R8 restart mid-frame, R4 foreign full ignored
        gen_mode = 2; frame(-1, -1, TOT - 1, 1'b0, 1'b0); // R8 R7 start in last slot
        gen_mode = 1; frame(5, -1, -1, 1'b0, 1'b0);    // R6 header full, abort
        gen_mode = 0; frame(-1, -1, -1, 1'b0, 1'b0);   // R9 next frame accepted, ovf stays
        gen_mode = 1; frame(-1, TOT - 1, TOT - 1, 1'b0, 1'b0); // R6 R8 same edge
        gen_mode = 1; frame(-1, 20, -1, 1'b0, 1'b0);   // R6 channel full
        frame(-1, -1, -1, 1'b1, 1'b0);                 // R8 held start
        frame(-1, -1, -1, 1'b1, 1'b0);                 // R8 saturation
        chk(int'(err_cnt_o) == EMAX, "R8", "saturated count", err_cnt_o, EMAX);

        // R1 reset from the middle of a frame
        cyc(1'b1, 1'b0, 1'b0);
        repeat (50) cyc(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        reset_check("mid-frame reset");
        rst = 1'b0;
        gen_mode = 2; frame(-1, -1, -1, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule